// File: doc/BRIEF.md
# Audio Clock and DMA-Request Watchdog

This block watches the serial audio interface for stalls. It checks four clocks, sampled into the system clock domain: the receive bit clock, the receive word clock, the transmit bit clock and the transmit word clock. It also watches the receive DMA request line. Each watched signal has a counter that runs on the system clock.

- For a clock, the counter measures how long it has been since that clock's last edge.
- For the DMA request, the counter measures how long the request has been held high without a break.

When a counter passes its programmed threshold, a sticky fault flag is set. The receive direction has one enable and one 20-bit threshold, and both of its clocks share them. The transmit direction has its own enable and threshold. The DMA check has its own enable and a 16-bit threshold.

Software reads the five flags and clears any of them by writing a 1 to that bit position. The block also drives a registered interrupt line, which is the OR of all flags.

Top module: `audio_clk_watchdog`

## Requirements
- R1: After reset, all five flags and the interrupt output are 0.
- R2: With `rx_chk_en` high, if the receive bit clock or receive word clock shows no edge for more than `rx_limit` system cycles, flag bit 0 (bit clock) or flag bit 1 (word clock) is set. Clocks whose edges come closer together than that set nothing.
- R3: With `tx_chk_en` high, the same rule applies to the transmit bit clock (flag bit 3) and the transmit word clock (flag bit 4), using `tx_limit`.
- R4: With `dma_chk_en` high, a DMA request held high for more than `dma_limit` consecutive cycles sets flag bit 2. A request held for exactly `dma_limit` cycles does not set it.
- R5: While a check is disabled, its counters stay at zero and its flags are never set, however long the fault condition lasts.
- R6: A cycle with `clr_we` high clears each flag whose `clr_data` bit is 1. Flags whose `clr_data` bit is 0 are left unchanged.
- R7: When a fault and a clear hit the same flag in the same cycle, the flag stays set.
- R8: `irq` is 1 exactly when at least one flag is 1. It changes in the same cycle as the flags.
- R9: Each clock input passes through a two-flop synchronizer. Both its rising and its falling edges restart that clock's counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sck_in | input | 1 | Receive bit clock, asynchronous |
| rx_lrck_in | input | 1 | Receive word clock, asynchronous |
| tx_sck_in | input | 1 | Transmit bit clock, asynchronous |
| tx_lrck_in | input | 1 | Transmit word clock, asynchronous |
| dma_req | input | 1 | Receive DMA request, system-clock domain |
| rx_chk_en | input | 1 | Enable for the receive clock checks |
| rx_limit | input | 20 | Shared threshold for the receive clock checks |
| tx_chk_en | input | 1 | Enable for the transmit clock checks |
| tx_limit | input | 20 | Shared threshold for the transmit clock checks |
| dma_chk_en | input | 1 | Enable for the DMA request check |
| dma_limit | input | 16 | Threshold for the DMA request check |
| clr_we | input | 1 | Flag clear strobe |
| clr_data | input | 5 | Write-1-to-clear mask |
| flags | output | 5 | Sticky fault flags |
| irq | output | 1 | OR of all flags, registered |

## Verification
A fault and a software clear can fall on the same flag in the same cycle. The bench provokes this by keeping a clock stopped, or the DMA request stuck high, so that the fault condition stays present. It then writes a 1 to that flag's bit. The flag must still read 1 on the cycle right after the write. Once the clock is restarted, the same write must bring the flag to 0. This shows that set-priority, not a stale value, kept the flag set.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int NFLAG       = 5;
  localparam int FLG_RX_SCK  = 0;
  localparam int FLG_RX_LRCK = 1;
  localparam int FLG_DMA     = 2;
  localparam int FLG_TX_SCK  = 3;
  localparam int FLG_TX_LRCK = 4;
  localparam int NCLK        = 4;
endpackage

// File: rtl/awd_edge_sync.sv
module awd_edge_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] edge_o
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  // both directions of transition count as activity (R9)
  assign edge_o = sync_q ^ prev_q;
endmodule

// File: rtl/awd_gap_counter.sv
module awd_gap_counter #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         fault
);
  localparam logic [W-1:0] CNT_MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en || restart) cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign fault = en && (cnt_q > limit);

  // R5: disabled counter rests at zero
  p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt_q == '0));
  // R9: activity restarts the count
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (en && restart) |=> (cnt_q == '0));
endmodule

// File: rtl/awd_flag_reg.sv
module awd_flag_reg #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_data,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] clr_mask, flags_d;

  assign clr_mask = clr_we ? clr_data : '0;
  // a pending set overrides a clear of the same bit (R7)
  assign flags_d  = (flags & ~clr_mask) | set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_d;
      irq   <= |flags_d;
    end
  end

  // R8
  p_irq_or_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (|flags));

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R6: a flag survives unless its bit is written with 1
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !(clr_we && clr_data[i])) |=> flags[i]);
    // R7: a set event always lands
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> flags[i]);
  end
endmodule

// File: rtl/audio_clk_watchdog.sv
module audio_clk_watchdog
  import awd_pkg::*;
#(
  parameter int CLK_CNT_W = 20,
  parameter int DMA_CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_sck_in,
  input  logic                 rx_lrck_in,
  input  logic                 tx_sck_in,
  input  logic                 tx_lrck_in,
  input  logic                 dma_req,
  input  logic                 rx_chk_en,
  input  logic [CLK_CNT_W-1:0] rx_limit,
  input  logic                 tx_chk_en,
  input  logic [CLK_CNT_W-1:0] tx_limit,
  input  logic                 dma_chk_en,
  input  logic [DMA_CNT_W-1:0] dma_limit,
  input  logic                 clr_we,
  input  logic [NFLAG-1:0]     clr_data,
  output logic [NFLAG-1:0]     flags,
  output logic                 irq
);
  // clock index order: rx sck, rx lrck, tx sck, tx lrck
  logic [NCLK-1:0] clk_raw, clk_edge, clk_fault;
  logic            dma_fault;
  logic [NFLAG-1:0] set_vec;

  assign clk_raw = {tx_lrck_in, tx_sck_in, rx_lrck_in, rx_sck_in};

  awd_edge_sync #(.N(NCLK)) u_sync (
    .clk(clk), .rst(rst), .din(clk_raw), .edge_o(clk_edge)
  );

  for (genvar i = 0; i < NCLK; i++) begin : g_clk
    localparam bit IS_TX = (i >= 2);
    logic                 en_i;
    logic [CLK_CNT_W-1:0] lim_i;
    assign en_i  = IS_TX ? tx_chk_en : rx_chk_en;
    assign lim_i = IS_TX ? tx_limit  : rx_limit;
    awd_gap_counter #(.W(CLK_CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .en(en_i), .restart(clk_edge[i]),
      .limit(lim_i), .fault(clk_fault[i])
    );
  end

  awd_gap_counter #(.W(DMA_CNT_W)) u_dma (
    .clk(clk), .rst(rst), .en(dma_chk_en), .restart(!dma_req),
    .limit(dma_limit), .fault(dma_fault)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[FLG_RX_SCK]  = clk_fault[0];
    set_vec[FLG_RX_LRCK] = clk_fault[1];
    set_vec[FLG_DMA]     = dma_fault;
    set_vec[FLG_TX_SCK]  = clk_fault[2];
    set_vec[FLG_TX_LRCK] = clk_fault[3];
  end

  awd_flag_reg #(.N(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .set_i(set_vec), .clr_we(clr_we),
    .clr_data(clr_data), .flags(flags), .irq(irq)
  );

  // R5: a disabled check raises no new flag
  p_rx_off_r5: assert property (@(posedge clk) disable iff (rst)
    !rx_chk_en |=> !$rose(flags[FLG_RX_SCK]) && !$rose(flags[FLG_RX_LRCK]));
  p_tx_off_r5: assert property (@(posedge clk) disable iff (rst)
    !tx_chk_en |=> !$rose(flags[FLG_TX_SCK]) && !$rose(flags[FLG_TX_LRCK]));
  p_dma_off_r5: assert property (@(posedge clk) disable iff (rst)
    !dma_chk_en |=> !$rose(flags[FLG_DMA]));
  // R4: a request that drops cannot start a new fault
  p_dma_low_r4: assert property (@(posedge clk) disable iff (rst)
    (!dma_req && !$past(dma_req)) |=> !$rose(flags[FLG_DMA]));
endmodule

// File: tb/audio_clk_watchdog_test.sv
module audio_clk_watchdog_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam logic [15:0] V_LIM [0:NV-1] = '{16'd5, 16'd5, 16'd0, 16'd10, 16'd1, 16'd3, 16'd20};
  localparam int          V_HLD [0:NV-1] = '{5, 6, 1, 3, 2, 3, 40};
  localparam bit          V_EXP [0:NV-1] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_sck = 1'b0, rx_lrck = 1'b0, tx_sck = 1'b0, tx_lrck = 1'b0;
  logic dma_req = 1'b0;
  logic rx_en = 1'b0, tx_en = 1'b0, dma_en = 1'b0;
  logic [19:0] rx_lim = 20'd10, tx_lim = 20'd12;
  logic [15:0] dma_lim = 16'd0;
  logic clr_we = 1'b0;
  logic [4:0] clr_data = '0;
  logic [4:0] flags;
  logic irq;
  logic [3:0] run = 4'b0000;   // toggle enables: rx sck, rx lrck, tx sck, tx lrck
  logic [1:0] div = '0;
  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  audio_clk_watchdog uut (
    .clk(clk), .rst(rst), .rx_sck_in(rx_sck), .rx_lrck_in(rx_lrck),
    .tx_sck_in(tx_sck), .tx_lrck_in(tx_lrck), .dma_req(dma_req),
    .rx_chk_en(rx_en), .rx_limit(rx_lim), .tx_chk_en(tx_en), .tx_limit(tx_lim),
    .dma_chk_en(dma_en), .dma_limit(dma_lim), .clr_we(clr_we),
    .clr_data(clr_data), .flags(flags), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // each running clock toggles every 4 system cycles
  always @(negedge clk) begin
    div <= div + 2'd1;
    if (div == 2'd3) begin
      if (run[0]) rx_sck  <= ~rx_sck;
      if (run[1]) rx_lrck <= ~rx_lrck;
      if (run[2]) tx_sck  <= ~tx_sck;
      if (run[3]) tx_lrck <= ~tx_lrck;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic w1c(input logic [4:0] m);
    @(negedge clk);
    clr_we = 1'b1; clr_data = m;
    @(negedge clk);
    clr_we = 1'b0; clr_data = '0;
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    check("R1 flags", flags, 5'b0);
    check("R1 irq", {4'b0, irq}, 5'b0);

    // R5: everything disabled, stuck request and dead clocks
    dma_req = 1'b1;
    wait_n(100);
    dma_req = 1'b0;
    wait_n(2);
    check("R5 disabled", flags, 5'b0);

    // R4 table walk
    dma_en = 1'b1;
    for (int k = 0; k < NV; k++) begin
      dma_lim = V_LIM[k];
      dma_req = 1'b1;
      wait_n(V_HLD[k]);
      dma_req = 1'b0;
      wait_n(3);
      check("R4 dma flag", {4'b0, flags[2]}, {4'b0, V_EXP[k]});
      check("R8 irq", {4'b0, irq}, {4'b0, V_EXP[k]});
      w1c(5'b00100);
      check("R6 dma clear", flags, 5'b0);
    end

    // R7: stuck request, clear collides with set
    dma_lim = 16'd0;
    dma_req = 1'b1;
    wait_n(4);
    w1c(5'b00100);
    check("R7 set wins dma", {4'b0, flags[2]}, 5'b1);
    dma_req = 1'b0;
    wait_n(2);
    w1c(5'b00100);
    check("R6 dma cleared", flags, 5'b0);
    dma_en = 1'b0;

    // R2 / R9: running clocks raise nothing
    run = 4'b1111;
    wait_n(10);
    rx_en = 1'b1; tx_en = 1'b1;
    wait_n(60);
    check("R2 R3 running clocks", flags, 5'b0);

    // R2: stop receive bit clock
    run[0] = 1'b0;
    wait_n(30);
    check("R2 rx sck fault", flags, 5'b00001);
    check("R8 irq set", {4'b0, irq}, 5'b1);
    w1c(5'b00000);
    check("R6 write 0 keeps", flags, 5'b00001);
    w1c(5'b00001);
    check("R7 set wins clock", flags, 5'b00001);
    run[0] = 1'b1;
    wait_n(12);
    w1c(5'b00001);
    check("R6 rx sck cleared", flags, 5'b0);
    check("R8 irq clear", {4'b0, irq}, 5'b0);

    // R2: stop receive word clock
    run[1] = 1'b0;
    wait_n(30);
    check("R2 rx lrck fault", flags, 5'b00010);
    run[1] = 1'b1;
    wait_n(12);
    w1c(5'b00010);

    // R3: transmit clocks
    run[2] = 1'b0; run[3] = 1'b0;
    wait_n(40);
    check("R3 tx faults", flags, 5'b11000);
    w1c(5'b01000);
    wait_n(1);
    // tx sck still dead, so it re-sets
    check("R6 partial clear", flags[4], 1'b1);
    tx_en = 1'b0;
    wait_n(2);
    w1c(5'b11000);
    wait_n(40);
    check("R5 tx disabled", flags, 5'b0);
    run[2] = 1'b1; run[3] = 1'b1;

    // R9: edges 4 cycles apart; both polarities count
    rx_lim = 20'd3;
    wait_n(60);
    check("R9 limit 3 no fault", flags, 5'b0);
    rx_lim = 20'd2;
    wait_n(20);
    check("R9 limit 2 faults", flags, 5'b00011);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule